// File: doc/BRIEF.md
# Thread Run-State Controller

This block keeps one run-enable bit for each hardware thread context and decides when each thread runs or is held. The decision for a thread uses two bits that the surrounding control-register file supplies: a halt bit and an activated bit. A thread runs only when it is activated and not halted. It must also lie within the number of contexts that a configuration field enables. The field holds the highest enabled thread index, so the enabled count is the field value plus one.

The block does not follow the register bits continuously. Any masked write to the control-register file raises a request. The block then re-evaluates every thread one cycle later, all threads in the same cycle. A request made while an evaluation is already waiting is merged into it. When a thread's run state changes in an evaluation, the block raises a one-cycle halt pulse or resume pulse on that thread's bit, so that the thread pipelines can act on the change.

Top module: `thread_run_ctrl`

## Requirements
- R1: A request sampled at clock edge t is acted on at edge t+1. The evaluation uses the halt bits, activated bits and thread-count field sampled at edge t+1, and the outputs change after edge t+1, not earlier.
- R2: A request sampled while an evaluation is pending merges into that evaluation. This includes a request sampled at the edge where the evaluation takes place. A merged request causes no second evaluation, so register changes that arrive after the evaluation edge stay unapplied until a later request.
- R3: Thread i is disabled by an evaluation when i is greater than the value of `max_tid`. The field holds the enabled thread count minus one.
- R4: Thread i is enabled by an evaluation only when it is in range and has halt bit 0 and activated bit 1. A halt bit of 1 or an activated bit of 0 disables it.
- R5: When an evaluation changes a thread from running to halted, bit i of `halt_pulse` is 1 for exactly the one cycle after the evaluation edge.
- R6: When an evaluation changes a thread from halted to running, bit i of `resume_pulse` is 1 for exactly the one cycle after the evaluation edge.
- R7: An evaluation that leaves a thread's run state unchanged raises no pulse for that thread. Both pulse vectors are 0 in every cycle that does not follow an evaluation edge.
- R8: While reset is low at a clock edge, `run_en` becomes 1 for thread 0 only, both pulse vectors become 0, and no evaluation is pending. This follows from thread 0 starting activated and not halted.
- R9: Without a request, changes on `halt_bits`, `act_bits` and `max_tid` leave `run_en` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_write | input | 1 | Request: a masked write to the control-register file happened this cycle |
| max_tid | input | CNT_W | Highest enabled thread index (enabled count minus one) |
| halt_bits | input | NUM_THREADS | Per-thread halt bit |
| act_bits | input | NUM_THREADS | Per-thread activated bit |
| run_en | output | NUM_THREADS | Per-thread run enable |
| halt_pulse | output | NUM_THREADS | One-cycle pulse when a thread stops |
| resume_pulse | output | NUM_THREADS | One-cycle pulse when a thread starts |

## Verification
The bench builds the block with four thread contexts, so `max_tid` is two bits wide and spans every enabled count from one thread to all threads. Each index can therefore be placed both inside and outside the configured range. Four threads also allow halting, inactive and running threads to coexist in a single evaluation, and they leave room to show a merged request losing a later halt-bit change while unaffected threads keep their state.

// File: rtl/trsc_pkg.sv
// Package: shared types and the per-thread run rule.
// Assumes: callers pass single-bit flags already qualified by range.
package trsc_pkg;

    // State held for one thread context.
    typedef struct packed {
        logic run;
        logic halt_p;
        logic resume_p;
    } thr_state_t;

    // A thread may run when enabled by count, not halted, and activated.
    function automatic logic thread_may_run(input logic in_range,
                                            input logic halt_bit,
                                            input logic act_bit);
        return in_range & ~halt_bit & act_bit;
    endfunction

endpackage

// File: rtl/trsc_eval_sched.sv
// Module: deferral and merging of re-evaluation requests.
// A request sets the pending flag unless one is already pending; a pending
// flag means "evaluate at this edge" and is cleared by that evaluation, which
// also absorbs any request sampled at the same edge.
module trsc_eval_sched (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic eval_now
);
    logic pend_q;

    // Pending flag: set by a fresh request, cleared by the evaluation.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (pend_q)
            pend_q <= 1'b0;
        else
            pend_q <= req;
    end

    assign eval_now = pend_q;
endmodule

// File: rtl/trsc_thread_slot.sv
// Module: run state of one thread context.
// On an evaluation it applies the run rule and records a halt or resume
// pulse when the state flips; outside evaluations the pulses are cleared.
// Assumes: IDX is a constant thread index below 2**CNT_W.
module trsc_thread_slot
    import trsc_pkg::*;
#(
    parameter int CNT_W = 2,
    parameter int IDX   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eval_now,
    input  logic [CNT_W-1:0] max_tid,
    input  logic             halt_bit,
    input  logic             act_bit,
    output thr_state_t       st
);
    localparam logic [CNT_W:0] MY_IDX   = (CNT_W+1)'(IDX);
    localparam logic           RST_RUN  = (IDX == 0);

    logic in_range;
    logic want;

    // Range check against the configured highest index, then the run rule.
    always_comb begin
        in_range = ({1'b0, max_tid} >= MY_IDX);
        want     = thread_may_run(in_range, halt_bit, act_bit);
    end

    // State update: reset value, evaluation, or pulse clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st.run      <= RST_RUN;
            st.halt_p   <= 1'b0;
            st.resume_p <= 1'b0;
        end else if (eval_now) begin
            st.run      <= want;
            st.halt_p   <= st.run & ~want;
            st.resume_p <= ~st.run & want;
        end else begin
            st.halt_p   <= 1'b0;
            st.resume_p <= 1'b0;
        end
    end
endmodule

// File: rtl/thread_run_ctrl.sv
// Module: top of the thread run-state controller.
// Re-evaluates every thread in parallel one cycle after a control-register
// write request, merging requests that arrive while one is pending.
// Assumes: halt and activated bits come straight from the register file and
// already reflect the write by the evaluation edge.
module thread_run_ctrl
    import trsc_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int CNT_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_write,
    input  logic [CNT_W-1:0]       max_tid,
    input  logic [NUM_THREADS-1:0] halt_bits,
    input  logic [NUM_THREADS-1:0] act_bits,
    output logic [NUM_THREADS-1:0] run_en,
    output logic [NUM_THREADS-1:0] halt_pulse,
    output logic [NUM_THREADS-1:0] resume_pulse
);
    logic eval_now;

    trsc_eval_sched u_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (reg_write),
        .eval_now (eval_now)
    );

    for (genvar i = 0; i < NUM_THREADS; i++) begin : g_thr
        thr_state_t st;

        trsc_thread_slot #(.CNT_W(CNT_W), .IDX(i)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .eval_now (eval_now),
            .max_tid  (max_tid),
            .halt_bit (halt_bits[i]),
            .act_bit  (act_bits[i]),
            .st       (st)
        );

        assign run_en[i]       = st.run;
        assign halt_pulse[i]   = st.halt_p;
        assign resume_pulse[i] = st.resume_p;
    end
endmodule

// File: rtl/thread_run_ctrl_chk.sv
// Module: assertion checker for thread_run_ctrl, attached by bind.
// Assumes: reset is held low from time zero until the first edges pass.
module thread_run_ctrl_chk #(
    parameter int NUM_THREADS = 4,
    parameter int CNT_W       = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   eval_now,
    input logic [CNT_W-1:0]       max_tid,
    input logic [NUM_THREADS-1:0] run_en,
    input logic [NUM_THREADS-1:0] halt_pulse,
    input logic [NUM_THREADS-1:0] resume_pulse
);
    logic [NUM_THREADS-1:0] range_mask;

    // Threads enabled by the configured count.
    always_comb begin
        for (int i = 0; i < NUM_THREADS; i++)
            range_mask[i] = (i <= int'(max_tid));
    end

    assert_merge_single_eval_R2: assert property (@(posedge clk) disable iff (!rst_n)
        eval_now |=> !eval_now);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_now |=> $stable(run_en));

    assert_pulse_after_eval_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (|halt_pulse || |resume_pulse) |-> $past(eval_now));

    assert_out_of_range_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eval_now |=> ((run_en & ~$past(range_mask)) == '0));

    assert_halt_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|halt_pulse) |-> ((halt_pulse & ~($past(run_en) & ~run_en)) == '0));

    assert_resume_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|resume_pulse) |-> ((resume_pulse & ~(~$past(run_en) & run_en)) == '0));
endmodule

bind thread_run_ctrl thread_run_ctrl_chk #(
    .NUM_THREADS (NUM_THREADS),
    .CNT_W       (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .eval_now     (eval_now),
    .max_tid      (max_tid),
    .run_en       (run_en),
    .halt_pulse   (halt_pulse),
    .resume_pulse (resume_pulse)
);

// File: tb/thread_run_ctrl_test.sv
// Bench: behavioural reference model compared every cycle, plus directed checks.
module thread_run_ctrl_test;
    localparam int NT = 4;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_write = 1'b0;
    logic [CW-1:0] max_tid = '0;
    logic [NT-1:0] halt_bits = '0;
    logic [NT-1:0] act_bits = '0;
    logic [NT-1:0] run_en, halt_pulse, resume_pulse;

    thread_run_ctrl #(.NUM_THREADS(NT)) uut (
        .clk(clk), .rst_n(rst_n), .reg_write(reg_write), .max_tid(max_tid),
        .halt_bits(halt_bits), .act_bits(act_bits), .run_en(run_en),
        .halt_pulse(halt_pulse), .resume_pulse(resume_pulse)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    // Reference model state
    logic [NT-1:0] m_run = 4'b0001;
    logic [NT-1:0] m_hp  = '0;
    logic [NT-1:0] m_rp  = '0;
    bit            m_pend = 0;

    task automatic check(string tag, logic [NT-1:0] act, logic [NT-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // One request cycle, returning after the evaluation edge.
    task automatic request();
        reg_write = 1'b1;
        step(1);
        reg_write = 1'b0;
        step(1);
    endtask

    // Reference model: one pending flag, evaluation the cycle after.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = '0; m_run[0] = 1'b1; m_hp = '0; m_rp = '0; m_pend = 0;
        end else if (m_pend) begin
            for (int i = 0; i < NT; i++) begin
                bit w;
                w = (i <= int'(max_tid)) && !halt_bits[i] && act_bits[i];
                m_hp[i]  = m_run[i] && !w;
                m_rp[i]  = !m_run[i] && w;
                m_run[i] = w;
            end
            m_pend = 0;
        end else begin
            m_hp = '0; m_rp = '0; m_pend = reg_write;
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R1 R3 R4 run_en vs model", run_en, m_run);
            check("R5 halt_pulse vs model", halt_pulse, m_hp);
            check("R6 R7 resume_pulse vs model", resume_pulse, m_rp);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            fails++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            finish_up();
        end
    end

    initial begin
        step(3);
        check("R8 reset run_en", run_en, 4'b0001);
        check("R8 reset halt_pulse", halt_pulse, 4'b0000);
        check("R8 reset resume_pulse", resume_pulse, 4'b0000);
        rst_n = 1'b1;

        // Deferral by one cycle, then resume of all threads.
        act_bits = 4'b1111; halt_bits = 4'b0000; max_tid = 2'd3;
        reg_write = 1'b1;
        step(1);
        reg_write = 1'b0;
        check("R1 outputs wait while pending", run_en, 4'b0001);
        step(1);
        check("R1 run_en after evaluation", run_en, 4'b1111);
        check("R6 resume pulse", resume_pulse, 4'b1110);
        step(1);
        check("R7 resume pulse lasts one cycle", resume_pulse, 4'b0000);

        // Changes without a request are ignored.
        halt_bits[2] = 1'b1;
        step(3);
        check("R9 no request no change", run_en, 4'b1111);

        // Request held across the evaluation edge merges.
        reg_write = 1'b1;
        step(1);
        step(1);
        reg_write = 1'b0;
        check("R5 halt of thread 2", run_en, 4'b1011);
        check("R5 halt pulse thread 2", halt_pulse, 4'b0100);
        halt_bits[3] = 1'b1;
        step(1);
        check("R2 merged request causes no evaluation", run_en, 4'b1011);
        check("R2 no second pulse", halt_pulse, 4'b0000);

        request();
        check("R5 halt of thread 3", halt_pulse, 4'b1000);
        check("R4 halted threads off", run_en, 4'b0011);

        // Evaluation with no change raises no pulse.
        request();
        check("R7 unchanged no halt pulse", halt_pulse, 4'b0000);
        check("R7 unchanged no resume pulse", resume_pulse, 4'b0000);

        // Thread count limits.
        halt_bits = 4'b0000;
        request();
        check("R6 resume threads 2 and 3", resume_pulse, 4'b1100);
        max_tid = 2'd1;
        request();
        check("R3 threads above count off", run_en, 4'b0011);
        check("R3 halt pulses for dropped threads", halt_pulse, 4'b1100);
        max_tid = 2'd0;
        request();
        check("R3 single thread", run_en, 4'b0001);

        // Run rule with mixed bits.
        max_tid = 2'd3; act_bits = 4'b1101; halt_bits = 4'b0001;
        request();
        check("R4 mixed halt and activated bits", run_en, 4'b1100);

        // Reset in mid-run.
        rst_n = 1'b0;
        step(1);
        check("R8 reset in mid-run", run_en, 4'b0001);
        check("R8 reset clears pulses", halt_pulse | resume_pulse, 4'b0000);
        rst_n = 1'b1;
        step(2);
        check("R8 nothing pending after reset", run_en, 4'b0001);

        finish_up();
    end
endmodule